// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It fetches from a private instruction store and reads and writes a private data store, both small word arrays. A program is written into the instruction store through a load port while the core is held in reset, and the data store can be seeded through a second load port. The core runs from address zero once reset is released.

It supports five register-to-register operations (add, subtract, AND, OR, signed set-on-less-than), word load, word store, branch on equal and an absolute jump within the current 256 MB region. Control is decoded in two levels. The opcode first gives a set of datapath controls plus a two-bit operation class. That class is then combined with the function field to pick the ALU operation. Debug read ports expose one register, one data word and the program counter, so results can be observed from outside.

Top module: `mono_cycle_cpu`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and every register reads 0. After release, the first instruction executed is the word at instruction index 0.
- R2: An instruction with opcode 0 writes its result to register [15:11]. It adds for funct 0x20, subtracts for 0x22, does AND for 0x24, does OR for 0x25 and does signed set-on-less-than for 0x2A. The sources are registers [25:21] and [20:16].
- R3: Opcode 35 (word load) writes register [20:16] with the data word at byte address reg[25:21] + sign-extended [15:0]. The word index is the byte address shifted right by two.
- R4: Opcode 43 (word store) writes register [20:16] to the data word at the same computed address and changes no register.
- R5: Opcode 4 (branch on equal) sets the next PC to PC+4+(sign-extended [15:0] << 2) when registers [25:21] and [20:16] are equal. Otherwise the next PC is PC+4. It writes nothing.
- R6: Opcode 2 (jump) sets the next PC to {(PC+4)[31:28], [25:0], 2'b00} and writes neither registers nor memory.
- R7: Register 0 always reads as zero, even after an instruction names it as destination.
- R8: Any other opcode is a no-op: no register or memory write, and the PC advances by 4.
- R9: Negative 16-bit immediates are sign-extended, both for load offsets and for backward branches.
- R10: Set-on-less-than compares as signed two's complement values: -3 < 7 gives 1, and 7 < -3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_we_i | input | 1 | Instruction store write enable |
| prog_addr_i | input | IAW | Instruction word index to write |
| prog_data_i | input | 32 | Instruction word to write |
| init_we_i | input | 1 | Data store preload write enable |
| init_addr_i | input | DAW | Data word index to preload |
| init_data_i | input | 32 | Data word to preload |
| dbg_reg_addr_i | input | 5 | Register to observe |
| dbg_reg_data_o | output | 32 | Value of the observed register |
| dbg_mem_addr_i | input | DAW | Data word index to observe |
| dbg_mem_data_o | output | 32 | Value of the observed data word |
| pc_o | output | 32 | Current program counter |

## Verification
Every piece of state here is architectural, so a wrong value shows up at the debug ports as soon as a later instruction has consumed it. The problems it can cause are a wrong register result, a wrong stored word, or a PC that goes down the wrong path. A wrongly decoded control bit usually shows up within one instruction: either an extra write to a register that should stay zero, or a skipped instruction whose destination keeps its reset value. Each directed program ends in a jump-to-self, so the final pc_o exposes any branch or jump target error for the whole run.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_we;
    logic     mem_re;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e alu_cls;
  } ctrl_t;
endpackage

// File: rtl/cpu_main_dec.sv
module cpu_main_dec
  import cpu_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_cls = CLS_ADD;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd  = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.alu_cls = CLS_FUNC;
      end
      OP_LOAD: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.mem_re  = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_cls = CLS_SUB;
      end
      OP_JUMP: ctrl_o.jump = 1'b1;
      default: ;  // unknown opcode: no-op
    endcase
  end
endmodule

// File: rtl/cpu_alu_dec.sv
module cpu_alu_dec
  import cpu_pkg::*;
(
  input  alu_cls_e   cls_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    fn_o
);
  always_comb begin
    fn_o = ALU_ADD;
    case (cls_i)
      CLS_ADD: fn_o = ALU_ADD;
      CLS_SUB: fn_o = ALU_SUB;
      default: begin
        case (funct_i[3:0])
          4'b0000: fn_o = ALU_ADD;
          4'b0010: fn_o = ALU_SUB;
          4'b0100: fn_o = ALU_AND;
          4'b0101: fn_o = ALU_OR;
          4'b1010: fn_o = ALU_SLT;
          default: fn_o = ALU_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  logic [W-1:0] diff;
  assign diff = a_i - b_i;

  always_comb begin
    unique case (fn_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = diff;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int W      = 32,
  parameter int NREGS  = 32,
  parameter int NRD    = 3,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]  rdata_o,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [W-1:0]          wdata_i
);
  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/mono_cycle_cpu.sv
module mono_cycle_cpu
  import cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_we_i,
  input  logic [IAW-1:0]  prog_addr_i,
  input  logic [31:0]     prog_data_i,
  input  logic            init_we_i,
  input  logic [DAW-1:0]  init_addr_i,
  input  logic [31:0]     init_data_i,
  input  logic [4:0]      dbg_reg_addr_i,
  output logic [31:0]     dbg_reg_data_o,
  input  logic [DAW-1:0]  dbg_mem_addr_i,
  output logic [31:0]     dbg_mem_data_o,
  output logic [31:0]     pc_o
);
  localparam int W = XLEN;

  logic [W-1:0] imem [IMEM_WORDS];
  logic [W-1:0] dmem [DMEM_WORDS];

  logic [W-1:0] pc_q, pc_next, pc_plus4, br_target, j_target;
  logic [W-1:0] instr, imm_ext;
  ctrl_t        ctrl;
  alu_fn_e      alu_fn;
  logic [W-1:0] alu_b, alu_res, wb_data, mem_rdata;
  logic         alu_zero;
  logic [4:0]   wr_reg;
  logic         rf_we, dmem_we;

  logic [2:0][4:0]   rf_raddr;
  logic [2:0][W-1:0] rf_rdata;

  // fetch
  assign instr    = imem[pc_q[IAW+1:2]];
  assign pc_plus4 = pc_q + 32'd4;

  always_ff @(posedge clk_i) begin
    if (prog_we_i) imem[prog_addr_i] <= prog_data_i;
  end

  // decode
  cpu_main_dec u_main_dec (
    .opcode_i(instr[31:26]),
    .ctrl_o  (ctrl)
  );

  cpu_alu_dec u_alu_dec (
    .cls_i  (ctrl.alu_cls),
    .funct_i(instr[5:0]),
    .fn_o   (alu_fn)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign wr_reg  = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we   = ctrl.reg_we;

  assign rf_raddr[0] = instr[25:21];
  assign rf_raddr[1] = instr[20:16];
  assign rf_raddr[2] = dbg_reg_addr_i;

  cpu_regfile #(.W(W), .NREGS(32), .NRD(3)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(rf_raddr),
    .rdata_o(rf_rdata),
    .we_i   (rf_we),
    .waddr_i(wr_reg),
    .wdata_i(wb_data)
  );

  // execute
  assign alu_b = ctrl.src_imm ? imm_ext : rf_rdata[1];

  cpu_alu #(.W(W)) u_alu (
    .a_i   (rf_rdata[0]),
    .b_i   (alu_b),
    .fn_i  (alu_fn),
    .res_o (alu_res),
    .zero_o(alu_zero)
  );

  // memory
  assign mem_rdata = ctrl.mem_re ? dmem[alu_res[DAW+1:2]] : '0;
  assign dmem_we   = ctrl.mem_we & rst_ni;

  always_ff @(posedge clk_i) begin
    if (init_we_i)     dmem[init_addr_i]       <= init_data_i;
    else if (dmem_we)  dmem[alu_res[DAW+1:2]]  <= rf_rdata[1];
  end

  assign wb_data = ctrl.wb_mem ? mem_rdata : alu_res;

  // next pc
  assign br_target = pc_plus4 + {imm_ext[W-3:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                    pc_next = j_target;
    else if (ctrl.branch && alu_zero) pc_next = br_target;
    else                              pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o           = pc_q;
  assign dbg_reg_data_o = rf_rdata[2];
  assign dbg_mem_data_o = dmem[dbg_mem_addr_i];
endmodule

// File: rtl/mono_cycle_cpu_chk.sv
module mono_cycle_cpu_chk
  import cpu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input ctrl_t       ctrl_i,
  input logic        zero_i,
  input logic        rf_we_i,
  input logic        dmem_we_i,
  input logic [4:0]  rs_addr_i,
  input logic [31:0] rs_data_i
);
  logic [31:0] pc4, br_off;
  assign pc4    = pc_i + 32'd4;
  assign br_off = {{14{instr_i[15]}}, instr_i[15:0], 2'b00};

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_pc_R1: assert (pc_i == 32'd0);
  end

  assert_store_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_i |-> instr_i[31:26] == OP_STORE);

  assert_regwrite_class_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |-> (instr_i[31:26] == OP_RTYPE || instr_i[31:26] == OP_LOAD));

  assert_zero_reg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_addr_i == 5'd0 |-> rs_data_i == 32'd0);

  assert_seq_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.jump && !(ctrl_i.branch && zero_i)) |=> pc_i == $past(pc4));

  assert_branch_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.branch && zero_i) |=> pc_i == $past(pc4) + $past(br_off));

  assert_jump_pc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.jump |=> pc_i == {$past(pc4[31:28]), $past(instr_i[25:0]), 2'b00});

  assert_jump_nowrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.jump |-> !rf_we_i && !dmem_we_i);
endmodule

bind mono_cycle_cpu mono_cycle_cpu_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_i     (pc_q),
  .instr_i  (instr),
  .ctrl_i   (ctrl),
  .zero_i   (alu_zero),
  .rf_we_i  (rf_we),
  .dmem_we_i(dmem_we),
  .rs_addr_i(rf_raddr[0]),
  .rs_data_i(rf_rdata[0])
);

// File: tb/mono_cycle_cpu_bench.sv
module mono_cycle_cpu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic        init_we = 1'b0;
  logic [5:0]  init_addr = '0;
  logic [31:0] init_data = '0;
  logic [4:0]  dbg_reg_addr = '0;
  logic [31:0] dbg_reg_data;
  logic [5:0]  dbg_mem_addr = '0;
  logic [31:0] dbg_mem_data;
  logic [31:0] pc;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_cycle_cpu #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_mono_cycle_cpu (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .prog_we_i     (prog_we),
    .prog_addr_i   (prog_addr),
    .prog_data_i   (prog_data),
    .init_we_i     (init_we),
    .init_addr_i   (init_addr),
    .init_data_i   (init_data),
    .dbg_reg_addr_i(dbg_reg_addr),
    .dbg_reg_data_o(dbg_reg_data),
    .dbg_mem_addr_i(dbg_mem_addr),
    .dbg_mem_data_o(dbg_mem_data),
    .pc_o          (pc)
  );

  function automatic logic [31:0] rt_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_ins(int widx);
    return {6'd2, 26'(widx)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, int r, logic [31:0] exp);
    dbg_reg_addr = 5'(r);
    #1;
    check(req, dbg_reg_data, exp);
  endtask

  task automatic chk_mem(string req, int w, logic [31:0] exp);
    dbg_mem_addr = 6'(w);
    #1;
    check(req, dbg_mem_data, exp);
  endtask

  task automatic put_ins(int a, logic [31:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 6'(a); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic put_data(int a, logic [31:0] d);
    @(negedge clk);
    init_we = 1'b1; init_addr = 6'(a); init_data = d;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < IW; i++) put_ins(i, j_ins(i));
    for (int i = 0; i < DW; i++) put_data(i, 32'd0);
  endtask

  task automatic run(int n);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    clear_all();
    @(negedge clk);
    check("R1 pc in reset", pc, 32'd0);
    chk_reg("R1 reg in reset", 5, 32'd0);
    put_ins(0, rt_ins(0, 0, 0, 6'h20));
    run(1);
    check("R1 first fetch from index 0", pc, 32'd4);
  endtask

  task automatic test_alu_mem();
    clear_all();
    put_data(0, 32'd7);
    put_data(1, 32'hFFFF_FFFD);
    put_data(2, 32'h0F0F_00FF);
    put_data(3, 32'h00FF_0F0F);
    put_data(6, 32'd24);
    put_ins(0,  i_ins(6'd35, 0, 1, 0));
    put_ins(1,  i_ins(6'd35, 0, 2, 4));
    put_ins(2,  i_ins(6'd35, 0, 6, 8));
    put_ins(3,  i_ins(6'd35, 0, 7, 12));
    put_ins(4,  rt_ins(1, 2, 3, 6'h20));
    put_ins(5,  rt_ins(1, 2, 4, 6'h22));
    put_ins(6,  rt_ins(6, 7, 5, 6'h24));
    put_ins(7,  rt_ins(6, 7, 8, 6'h25));
    put_ins(8,  rt_ins(2, 1, 9, 6'h2A));
    put_ins(9,  rt_ins(1, 2, 10, 6'h2A));
    put_ins(10, rt_ins(1, 1, 0, 6'h20));
    put_ins(11, i_ins(6'd43, 0, 3, 16));
    put_ins(12, i_ins(6'd35, 0, 13, 24));
    put_ins(13, i_ins(6'd35, 13, 14, -8));
    run(20);
    chk_reg("R3 load negative word", 2, 32'hFFFF_FFFD);
    chk_reg("R2 add", 3, 32'd4);
    chk_reg("R2 sub", 4, 32'd10);
    chk_reg("R2 and", 5, 32'h000F_000F);
    chk_reg("R2 or", 8, 32'h0FFF_0FFF);
    chk_reg("R10 slt -3<7", 9, 32'd1);
    chk_reg("R10 slt 7<-3", 10, 32'd0);
    chk_reg("R7 r0 stays zero", 0, 32'd0);
    chk_mem("R4 store word", 4, 32'd4);
    chk_reg("R4 store leaves rt", 3, 32'd4);
    chk_reg("R9 load negative offset", 14, 32'd4);
    check("R6 halt pc", pc, 32'd56);
  endtask

  task automatic test_flow();
    clear_all();
    put_data(0, 32'd5);
    put_data(1, 32'd5);
    put_data(2, 32'd6);
    put_data(3, 32'd1);
    put_ins(0,  i_ins(6'd35, 0, 1, 0));
    put_ins(1,  i_ins(6'd35, 0, 2, 4));
    put_ins(2,  i_ins(6'd35, 0, 3, 8));
    put_ins(3,  i_ins(6'd35, 0, 9, 12));
    put_ins(4,  i_ins(6'd4, 1, 3, 2));
    put_ins(5,  rt_ins(1, 1, 4, 6'h20));
    put_ins(6,  i_ins(6'd4, 1, 2, 2));
    put_ins(7,  rt_ins(1, 1, 5, 6'h20));
    put_ins(8,  rt_ins(1, 1, 5, 6'h20));
    put_ins(9,  rt_ins(6, 9, 6, 6'h20));
    put_ins(10, i_ins(6'd4, 6, 9, -2));
    put_ins(11, i_ins(6'h3F, 0, 7, 16));
    put_ins(12, j_ins(14));
    put_ins(13, rt_ins(1, 1, 8, 6'h20));
    put_ins(14, rt_ins(1, 2, 10, 6'h20));
    run(30);
    chk_reg("R5 not-taken falls through", 4, 32'd10);
    chk_reg("R5 taken skips", 5, 32'd0);
    chk_reg("R9 backward branch loops once", 6, 32'd2);
    chk_reg("R8 unknown opcode no write", 7, 32'd0);
    chk_mem("R8 unknown opcode no store", 5, 32'd0);
    chk_reg("R6 jump skips", 8, 32'd0);
    chk_reg("R6 jump target executed", 10, 32'd10);
    check("R6 final pc", pc, 32'd60);
  endtask

  task automatic test_reset_again();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 pc after mid-run reset", pc, 32'd0);
    chk_reg("R1 regs after mid-run reset", 10, 32'd0);
  endtask

  initial begin
    test_reset();
    test_alu_mem();
    test_flow();
    test_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule